// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns two reset causes into one clean, stretched reset for the rest of a chip. The first cause is a supply-fail flag from an analog comparator. The second is an active-low manual reset request from a pin or a switch. Both inputs are brought into the clock domain through two flip-flops. Each then passes through its own persistence filter, so that short dips on the supply flag and contact bounce on the manual pin are discarded. The block asserts its reset output as soon as a filtered cause is present and keeps it asserted while that cause lasts. After every cause has cleared, it holds reset for a timeout whose length depends on which cause started the reset.

All time values are parameters in microseconds and are converted to clock cycles using a clock-frequency parameter. The output polarity is also a parameter, so one design serves both active-high and active-low reset nets. An asynchronous power-on reset input starts the block with reset asserted, and the block then runs a full supply timeout before it releases. A two-bit status output reports which cause last started the reset. All pins are plain level signals, so the block has no handshake at its edge.

Top module: `sup_reset_gen`

## Requirements
- R1: Once the filtered supply-fail flag is active, the reset output is asserted. It stays asserted for as long as the flag remains high.
- R2: A supply-fail high pulse shorter than SUP_FILT_US worth of cycles is ignored and the reset output stays released. A pulse of at least that length plus 3 cycles of input latency asserts reset.
- R3: A low level on `manual_n` that outlasts the filter asserts reset, and reset stays asserted while `manual_n` stays low.
- R4: A low pulse on `manual_n` shorter than MAN_FILT_US worth of cycles is ignored, and the reset output stays released.
- R5: After the supply flag clears, reset is released SUP_TIMEOUT_US cycles plus 3 cycles of sync and filter latency after the flag went low. It is still asserted one cycle before that point.
- R6: After `manual_n` returns high, reset is released MAN_HOLD_US cycles plus 3 cycles after the release. It is still asserted one cycle before that point.
- R7: If a cause becomes active again during a timeout, the timeout starts again from zero once all causes are clear. Its length is set by the cause that started most recently.
- R8: After the asynchronous reset `arst_n` is released, the reset output stays asserted for SUP_TIMEOUT_US cycles and then releases.
- R9: With ACTIVE_HIGH=1 the output is 1 while reset is asserted. With ACTIVE_HIGH=0 the output is 0 while reset is asserted. The two variants are exact complements.
- R10: `last_cause` reads 0 after power-up. It reads 1 when the supply flag started the latest reset and 2 when the manual input did. If both causes start in the same cycle, the supply cause wins.
- R11: Reset is asserted one cycle after the manual filter accepts its input. That is at most MAN_FILT_US cycles plus 3 after `manual_n` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| supply_fail | input | 1 | Comparator flag, high while the supply is below the trip level |
| manual_n | input | 1 | Manual reset request, active low |
| rst_out | output | 1 | Stretched reset; its polarity is set by ACTIVE_HIGH |
| last_cause | output | 2 | 0 power-up, 1 supply, 2 manual |

## Verification
The supply flag is tested with a dip shorter than its filter and with a long failure. The first checks that the filter rejects the dip, and the second checks both the assertion latency and the exact release cycle. The manual input gets the same pair of patterns: a bounce shorter than its filter and a long press. Because the manual hold has a different length from the supply timeout, these tests also show which hold is applied. In the last pattern, a manual press arrives during a running supply timeout. Reset must then be held for the full manual period measured from the press release. This separates a counter that restarts from one that keeps running, and it confirms the status update. A second instance with the opposite polarity is compared against the first at every checkpoint.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    CAUSE_POWER  = 2'd0,
    CAUSE_SUPPLY = 2'd1,
    CAUSE_MANUAL = 2'd2
  } cause_e;

  function automatic int unsigned us_to_cycles(input int unsigned clk_hz, input int unsigned us);
    return (clk_hz / 1_000_000) * us;
  endfunction
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= {STAGES{IDLE}};
    else         chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sup_glitch_filter.sv
module sup_glitch_filter #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic din,
  output logic act
);
  localparam int unsigned    CW   = $clog2(LEN + 1);
  localparam logic [CW-1:0]  LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      act   <= 1'b0;
    end else if (!din) begin
      cnt_q <= '0;
      act   <= 1'b0;
    end else if (!act) begin
      if (cnt_q == LAST) act   <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  // checker: consecutive high samples seen on din, saturating at LEN
  logic [CW:0] run_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                       run_q <= '0;
    else if (!din)                     run_q <= '0;
    else if (run_q < (CW+1)'(LEN))     run_q <= run_q + 1'b1;
  end

  AST_FILT_PERSIST: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(act) |-> (run_q >= (CW+1)'(LEN)));                 // R2 R4
  AST_FILT_DROP: assert property (@(posedge clk) disable iff (!arst_n)
    !din |=> !act);                                          // R5 R6
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
  import sup_pkg::*;
#(
  parameter int unsigned CLK_HZ         = 250_000_000,
  parameter int unsigned SUP_TIMEOUT_US = 240_000,
  parameter int unsigned MAN_HOLD_US    = 240_000,
  parameter int unsigned SUP_FILT_US    = 80,
  parameter int unsigned MAN_FILT_US    = 2,
  parameter bit          ACTIVE_HIGH    = 1'b0
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       supply_fail,
  input  logic       manual_n,
  output logic       rst_out,
  output logic [1:0] last_cause
);
  localparam int unsigned SUP_HOLD = us_to_cycles(CLK_HZ, SUP_TIMEOUT_US);
  localparam int unsigned MAN_HOLD = us_to_cycles(CLK_HZ, MAN_HOLD_US);
  localparam int unsigned SUP_FLT  = us_to_cycles(CLK_HZ, SUP_FILT_US);
  localparam int unsigned MAN_FLT  = us_to_cycles(CLK_HZ, MAN_FILT_US);
  localparam int unsigned MAX_HOLD = (SUP_HOLD > MAN_HOLD) ? SUP_HOLD : MAN_HOLD;
  localparam int unsigned MIN_HOLD = (SUP_HOLD < MAN_HOLD) ? SUP_HOLD : MAN_HOLD;
  localparam int unsigned HW       = $clog2(MAX_HOLD + 1);
  localparam logic [HW-1:0] SUP_LAST = HW'(SUP_HOLD - 1);
  localparam logic [HW-1:0] MAN_LAST = HW'(MAN_HOLD - 1);

  logic sup_s, man_req_s, sup_act, man_act;

  sup_sync #(.STAGES(2), .IDLE(1'b0)) u_sync_sup (
    .clk(clk), .arst_n(arst_n), .din(supply_fail), .dout(sup_s));
  sup_sync #(.STAGES(2), .IDLE(1'b0)) u_sync_man (
    .clk(clk), .arst_n(arst_n), .din(~manual_n), .dout(man_req_s));

  sup_glitch_filter #(.LEN(SUP_FLT)) u_filt_sup (
    .clk(clk), .arst_n(arst_n), .din(sup_s), .act(sup_act));
  sup_glitch_filter #(.LEN(MAN_FLT)) u_filt_man (
    .clk(clk), .arst_n(arst_n), .din(man_req_s), .act(man_act));

  logic          asserted_q, sup_d, man_d;
  logic [HW-1:0] hold_q;
  cause_e        cause_q;
  logic          cause_active;
  logic [HW-1:0] hold_last;

  assign cause_active = sup_act | man_act;
  assign hold_last    = (cause_q == CAUSE_MANUAL) ? MAN_LAST : SUP_LAST;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sup_d   <= 1'b0;
      man_d   <= 1'b0;
      cause_q <= CAUSE_POWER;
    end else begin
      sup_d <= sup_act;
      man_d <= man_act;
      if (sup_act && !sup_d)      cause_q <= CAUSE_SUPPLY;
      else if (man_act && !man_d) cause_q <= CAUSE_MANUAL;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      asserted_q <= 1'b1;
      hold_q     <= '0;
    end else if (cause_active) begin
      asserted_q <= 1'b1;
      hold_q     <= '0;
    end else if (asserted_q) begin
      if (hold_q == hold_last) asserted_q <= 1'b0;
      else                     hold_q     <= hold_q + 1'b1;
    end
  end

  generate
    if (ACTIVE_HIGH) begin : g_pol_high
      assign rst_out = asserted_q;
    end else begin : g_pol_low
      assign rst_out = ~asserted_q;
    end
  endgenerate

  assign last_cause = cause_q;

  // checker: consecutive cycles with no cause present, saturating
  logic [HW:0] idle_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                         idle_q <= '0;
    else if (cause_active)               idle_q <= '0;
    else if (idle_q <= (HW+1)'(MAX_HOLD)) idle_q <= idle_q + 1'b1;
  end

  AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
    cause_active |=> asserted_q);                                  // R1 R3
  AST_MAN_FAST: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(man_act) |=> asserted_q);                                // R11
  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(asserted_q) |-> (idle_q >= (HW+1)'(MIN_HOLD)));          // R5 R6 R7
  AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!arst_n)
    last_cause != 2'd3);                                           // R10
  AST_SUP_WINS: assert property (@(posedge clk) disable iff (!arst_n)
    ($rose(sup_act) && $rose(man_act)) |=> (last_cause == 2'd1));  // R10
endmodule

// File: tb/tb_sup_reset_gen.sv
`timescale 1ns/1ps
module tb_sup_reset_gen;
  localparam int SUPT = 200;
  localparam int MANT = 300;
  localparam int SUPF = 60;
  localparam int MANF = 8;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic supply_fail = 1'b0;
  logic manual_n = 1'b1;
  logic rst_lo, rst_hi;
  logic [1:0] cause_lo, cause_hi;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sup_reset_gen #(.CLK_HZ(1_000_000), .SUP_TIMEOUT_US(SUPT), .MAN_HOLD_US(MANT),
    .SUP_FILT_US(SUPF), .MAN_FILT_US(MANF), .ACTIVE_HIGH(1'b0)) dut (
    .clk(clk), .arst_n(arst_n), .supply_fail(supply_fail), .manual_n(manual_n),
    .rst_out(rst_lo), .last_cause(cause_lo));

  sup_reset_gen #(.CLK_HZ(1_000_000), .SUP_TIMEOUT_US(SUPT), .MAN_HOLD_US(MANT),
    .SUP_FILT_US(SUPF), .MAN_FILT_US(MANF), .ACTIVE_HIGH(1'b1)) dut_hi (
    .clk(clk), .arst_n(arst_n), .supply_fail(supply_fail), .manual_n(manual_n),
    .rst_out(rst_hi), .last_cause(cause_hi));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // reset state as seen on the active-low port, plus polarity cross-check
  task automatic check_rst(input logic exp, input string req, input string what);
    check(~rst_lo, exp, req, what);
    check(rst_hi, exp, "R9", {what, " active-high copy"});
  endtask

  task automatic check_cause(input logic [1:0] exp, input string what);
    checks++;
    if (cause_lo !== exp) begin
      errors++;
      $display("FAIL R10 %s: actual %0d expected %0d", what, cause_lo, exp);
    end
  endtask

  task automatic t_power_up;
    cyc(3);
    check_rst(1'b1, "R8", "asserted during power-on reset");
    check(rst_lo, 1'b0, "R9", "active-low level while asserted");
    arst_n = 1'b1;
    cyc(SUPT - 2);
    check_rst(1'b1, "R8", "still held before timeout");
    check_cause(2'd0, "power-up cause");
    cyc(3);
    check_rst(1'b0, "R8", "released after timeout");
    check(rst_lo, 1'b1, "R9", "active-low level when released");
  endtask

  task automatic t_supply_glitch;
    int seen = 0;
    supply_fail = 1'b1;
    cyc(SUPF - 20);
    supply_fail = 1'b0;
    for (int i = 0; i < SUPF + 20; i++) begin
      @(negedge clk);
      if (~rst_lo) seen++;
    end
    check(seen != 0, 1'b0, "R2", "short supply dip ignored");
  endtask

  task automatic t_supply_long;
    supply_fail = 1'b1;
    cyc(SUPF + 1);
    check_rst(1'b0, "R2", "not yet accepted");
    cyc(2);
    check_rst(1'b1, "R1", "asserted after filter");
    check_cause(2'd1, "supply cause");
    cyc(100);
    check_rst(1'b1, "R1", "held while flag present");
    supply_fail = 1'b0;
    cyc(SUPT + 1);
    check_rst(1'b1, "R5", "held one cycle before release");
    cyc(3);
    check_rst(1'b0, "R5", "released after supply timeout");
  endtask

  task automatic t_manual_bounce;
    int seen = 0;
    manual_n = 1'b0;
    cyc(MANF - 2);
    manual_n = 1'b1;
    for (int i = 0; i < MANF + 10; i++) begin
      @(negedge clk);
      if (~rst_lo) seen++;
    end
    check(seen != 0, 1'b0, "R4", "short manual pulse ignored");
  endtask

  task automatic t_manual_long;
    manual_n = 1'b0;
    cyc(MANF + 1);
    check_rst(1'b0, "R11", "not before filter accepts");
    cyc(2);
    check_rst(1'b1, "R11", "asserted right after filter");
    check_cause(2'd2, "manual cause");
    cyc(50);
    check_rst(1'b1, "R3", "held while manual low");
    manual_n = 1'b1;
    cyc(MANT + 1);
    check_rst(1'b1, "R6", "held one cycle before release");
    cyc(3);
    check_rst(1'b0, "R6", "released after manual hold");
  endtask

  task automatic t_restart;
    supply_fail = 1'b1;
    cyc(SUPF + 20);
    supply_fail = 1'b0;
    cyc(100);
    check_rst(1'b1, "R7", "supply timeout running");
    manual_n = 1'b0;
    cyc(20);
    manual_n = 1'b1;
    check_cause(2'd2, "manual took over during timeout");
    cyc(MANT + 1);
    check_rst(1'b1, "R7", "timeout restarted by manual press");
    cyc(3);
    check_rst(1'b0, "R7", "released after restarted hold");
  endtask

  initial begin
    cyc(200_000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_power_up();
    t_supply_glitch();
    t_supply_long();
    t_manual_bounce();
    t_manual_long();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule